// File: doc/BRIEF.md
# Three-Wire Byte Handshake Controller

This block is the host end of a byte link to a peripheral microcontroller. The two sides share one 8-bit shift register whose serial timing lives elsewhere. Three handshake lines coordinate the exchange: an active-low request from the peripheral, and transfer-in-progress and acknowledge outputs from the host. Every step of the controller is paced by a one-cycle done pulse from the shift register. No other event advances the exchange, apart from the start of a queued transmission while the link is idle.

Inbound packets have variable length and go into a receive buffer. The acknowledge line toggles once per byte. A packet is delivered when the peripheral releases its request. If the request is asserted again at that point, the next packet is received without returning to idle. Outbound packets are written into a send buffer and then queued, or a three-byte automatic-polling command is queued with a single strobe. The first byte of each transmission is a probe. If the peripheral's request is seen low when that byte completes, the host backs off, the exchange turns into a reception, and the queued packet is tried again when that reception ends.

Top module: `hs_link_ctrl`

## Requirements
- R1: After reset, `xfer_no` and `ack_o` are high, `sr_out_o`, `tx_pend_o`, `rx_valid_o`, `sr_load_o` and `sr_rd_o` are low, and the controller is idle.
- R2: The exchange advances only on a `sr_done_i` pulse, or on a queued start while idle. A done pulse while idle with `req_ni` high changes no output.
- R3: A done pulse while idle with `req_ni` low drives `xfer_no` low, and the controller begins receiving.
- R4: While receiving, each done pulse captures `sr_rdata_i` and gives a one-cycle `sr_rd_o` pulse. If `req_ni` is low, `ack_o` toggles. If `req_ni` is high, `ack_o` and `xfer_no` go high and the packet ends.
- R5: The done pulse after a packet ends gives a one-cycle `rx_valid_o` with `rx_len_o` equal to the stored byte count. Byte i sits at `rx_data_o[8i+7:8i]`. If `req_ni` is low on that pulse, `xfer_no` goes low and a new packet is stored from index 0. Otherwise the controller goes idle.
- R6: Bytes beyond RX_DEPTH in one packet are dropped. `rx_len_o` then reads RX_DEPTH, and the stored bytes are kept.
- R7: `tx_go_i` is accepted only while `tx_pend_o` is low and `tx_len_i` is between 2 and TX_DEPTH. `tx_wr_i` writes only while `tx_pend_o` is low. Other requests are ignored. `tx_pend_o` rises one cycle after an accepted request.
- R8: In the cycle after a request is accepted, an idle controller with `req_ni` high and no done pulse starts sending. It pulses `sr_load_o` with byte 0, sets `sr_out_o` and drives `xfer_no` low. With `req_ni` low, nothing starts and the packet stays pending.
- R9: On the first-byte done pulse with `req_ni` high, byte 1 is loaded and `ack_o` toggles.
- R10: On each later done pulse, the next byte is loaded and `ack_o` toggles while bytes remain. After the last byte, `tx_pend_o` falls, `sr_out_o` clears, `sr_rd_o` pulses, and `ack_o` and `xfer_no` go high.
- R11: On the first-byte done pulse with `req_ni` low (a collision), `sr_out_o` clears, `sr_rd_o` pulses, `ack_o` and `xfer_no` go high, the controller goes idle, and `tx_pend_o` stays high.
- R12: When a packet-end done pulse sees `req_ni` high while a packet is pending, the transmission of byte 0 starts in that same step.
- R13: `poll_set_i` queues the bytes 0x01, 0x01 and then 0x01 (if `poll_on_i` is high) or 0x00, with length 3. It takes priority over `tx_go_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_done_i | input | 1 | Shift register finished a byte (one-cycle pulse) |
| req_ni | input | 1 | Peripheral request, active low |
| sr_rdata_i | input | 8 | Shift register contents |
| sr_wdata_o | output | 8 | Byte to load into the shift register |
| sr_load_o | output | 1 | Load strobe for `sr_wdata_o` |
| sr_rd_o | output | 1 | Read strobe of the shift register |
| sr_out_o | output | 1 | Shift direction, 1 = host drives out |
| xfer_no | output | 1 | Transfer in progress, active low |
| ack_o | output | 1 | Byte acknowledge level |
| tx_wr_i | input | 1 | Send buffer write strobe |
| tx_waddr_i | input | $clog2(TX_DEPTH) | Send buffer write index |
| tx_wdata_i | input | 8 | Send buffer write byte |
| tx_go_i | input | 1 | Queue the send buffer |
| tx_len_i | input | $clog2(TX_DEPTH+1) | Byte count to send |
| poll_set_i | input | 1 | Queue the polling command |
| poll_on_i | input | 1 | Polling command value: enable/disable |
| tx_pend_o | output | 1 | A packet is queued or in flight |
| rx_valid_o | output | 1 | Received packet delivered (one cycle) |
| rx_len_o | output | $clog2(RX_DEPTH+1) | Delivered byte count |
| rx_data_o | output | 8*RX_DEPTH | Receive buffer, byte i at bits 8i+7:8i |

## Verification
Every output is registered. The result of a done pulse therefore appears in the cycle after the clock edge that sampled it, and a strobe is high for exactly that one cycle. A queued transmission shows its first load two cycles after the request is sampled: one edge to accept it and one to start. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares every output on the following falling edge, so each strobe is checked in the single cycle it is due. Targeted checks read outputs at the same falling edge that closes each stimulus step.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;
  typedef enum logic [2:0] {
    ST_LISTEN,
    ST_RECV,
    ST_RECV_END,
    ST_SEND_START,
    ST_SEND
  } link_st_e;

  localparam logic [7:0] POLL_KIND = 8'h01;
  localparam logic [7:0] POLL_CODE = 8'h01;
endpackage

// File: rtl/hs_tx_buf.sv
module hs_tx_buf #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          go_i,
  input  logic [CW-1:0] len_i,
  input  logic          poll_set_i,
  input  logic          poll_on_i,
  input  logic          done_i,
  input  logic [CW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o,
  output logic [CW-1:0] len_o,
  output logic          acc_o
);
  import hs_link_pkg::*;

  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] len_q;
  logic          idle, go_ok, poll_acc, wr_ok;

  assign idle     = (len_q == '0);
  assign go_ok    = go_i && (len_i >= CW'(2)) && (len_i <= CW'(DEPTH));
  assign poll_acc = idle && poll_set_i;
  assign wr_ok    = idle && wr_i && !poll_set_i;
  assign acc_o    = idle && (poll_set_i || go_ok);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [7:0] poll_byte;
    if (g == 0) begin : g_b0
      assign poll_byte = POLL_KIND;
    end else if (g == 1) begin : g_b1
      assign poll_byte = POLL_CODE;
    end else begin : g_bn
      assign poll_byte = {7'd0, poll_on_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (poll_acc && g < 3) begin
        mem_q[g] <= poll_byte;
      end else if (wr_ok && waddr_i == AW'(g)) begin
        mem_q[g] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
    end else if (done_i) begin
      len_q <= '0;
    end else if (poll_acc) begin
      len_q <= CW'(3);
    end else if (acc_o) begin
      len_q <= len_i;
    end
  end

  assign rd_data_o = (rd_idx_i < CW'(DEPTH)) ? mem_q[rd_idx_i[AW-1:0]] : 8'h00;
  assign len_o     = len_q;

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q != '0 && !done_i) |=> $stable(len_q)) else $error("pending length moved"); // R7
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q == '0) || (len_q >= CW'(2) && len_q <= CW'(DEPTH))) else $error("bad length"); // R7

  initial begin
    assert (DEPTH >= 3) else $error("send buffer too small for polling command"); // R13
  end
endmodule

// File: rtl/hs_rx_buf.sv
module hs_rx_buf #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [7:0]         wdata_i,
  input  logic               flush_i,
  output logic               valid_o,
  output logic [CW-1:0]      len_o,
  output logic [8*DEPTH-1:0] data_o
);
  logic [CW-1:0] idx_q, len_q;
  logic          valid_q;
  logic          room;

  assign room = (idx_q < CW'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
      end else if (wr_i && room && idx_q == CW'(g)) begin
        byte_q <= wdata_i;
      end
    end
    assign data_o[8*g +: 8] = byte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      len_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= flush_i;
      if (flush_i) begin
        len_q <= idx_q;
        idx_q <= '0;
      end else if (wr_i && room) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign len_o   = len_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= CW'(DEPTH)) else $error("receive index past buffer"); // R6
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!room && !flush_i) |=> $stable(data_o)) else $error("full buffer overwritten"); // R6
  AST_WR_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && flush_i)) else $error("capture and delivery collide"); // R5
endmodule

// File: rtl/hs_link_fsm.sv
module hs_link_fsm #(
  parameter int TX_DEPTH = 8,
  localparam int CW = $clog2(TX_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_i,
  input  logic          req_ni,
  input  logic [CW-1:0] tx_len_i,
  input  logic [7:0]    tx_byte_i,
  input  logic          acc_i,
  output logic [CW-1:0] tx_idx_o,
  output logic          tx_done_o,
  output logic          rx_wr_o,
  output logic          rx_flush_o,
  output logic [7:0]    sr_wdata_o,
  output logic          sr_load_o,
  output logic          sr_rd_o,
  output logic          sr_out_o,
  output logic          xfer_no,
  output logic          ack_o
);
  import hs_link_pkg::*;

  link_st_e      st_q, st_d;
  logic [CW-1:0] idx_q, idx_d;
  logic          xip_q, xip_d, ack_q, ack_d, dir_q, dir_d;
  logic          load_q, load_d, rd_q, rd_d, kick_q, kick_d;
  logic [7:0]    wdata_q, wdata_d;
  logic          start, pend;

  assign pend = (tx_len_i != '0);

  always_comb begin
    unique case (st_q)
      ST_SEND_START: tx_idx_o = CW'(1);
      ST_SEND:       tx_idx_o = idx_q;
      default:       tx_idx_o = '0;
    endcase
  end

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    xip_d      = xip_q;
    ack_d      = ack_q;
    dir_d      = dir_q;
    wdata_d    = wdata_q;
    load_d     = 1'b0;
    rd_d       = 1'b0;
    tx_done_o  = 1'b0;
    rx_wr_o    = 1'b0;
    rx_flush_o = 1'b0;
    start      = 1'b0;
    if (ev_i) begin
      unique case (st_q)
        ST_LISTEN: begin
          if (!req_ni) begin
            xip_d = 1'b0;
            st_d  = ST_RECV;
          end
        end
        ST_RECV: begin
          rx_wr_o = 1'b1;
          rd_d    = 1'b1;
          if (!req_ni) begin
            ack_d = ~ack_q;
          end else begin
            ack_d = 1'b1;
            xip_d = 1'b1;
            st_d  = ST_RECV_END;
          end
        end
        ST_RECV_END: begin
          rx_flush_o = 1'b1;
          if (!req_ni) begin
            xip_d = 1'b0;
            st_d  = ST_RECV;
          end else begin
            st_d  = ST_LISTEN;
            start = pend;
          end
        end
        ST_SEND_START: begin
          if (!req_ni) begin
            // peripheral won the line: back off, discard shifted-in byte
            dir_d = 1'b0;
            rd_d  = 1'b1;
            xip_d = 1'b1;
            ack_d = 1'b1;
            st_d  = ST_LISTEN;
          end else begin
            load_d  = 1'b1;
            wdata_d = tx_byte_i;
            ack_d   = ~ack_q;
            idx_d   = CW'(2);
            st_d    = ST_SEND;
          end
        end
        ST_SEND: begin
          if (idx_q < tx_len_i) begin
            load_d  = 1'b1;
            wdata_d = tx_byte_i;
            ack_d   = ~ack_q;
            idx_d   = idx_q + 1'b1;
          end else begin
            tx_done_o = 1'b1;
            dir_d     = 1'b0;
            rd_d      = 1'b1;
            ack_d     = 1'b1;
            xip_d     = 1'b1;
            st_d      = ST_LISTEN;
          end
        end
        default: st_d = ST_LISTEN;
      endcase
    end else if (st_q == ST_LISTEN && kick_q && pend && req_ni) begin
      start = 1'b1;
    end
    if (start) begin
      st_d    = ST_SEND_START;
      dir_d   = 1'b1;
      load_d  = 1'b1;
      wdata_d = tx_byte_i;
      xip_d   = 1'b0;
    end
  end

  // a fresh queue request gets one attempt from idle; otherwise wait for a packet end
  assign kick_d = acc_i || (kick_q && st_q == ST_LISTEN && ev_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_LISTEN;
      idx_q   <= '0;
      xip_q   <= 1'b1;
      ack_q   <= 1'b1;
      dir_q   <= 1'b0;
      wdata_q <= '0;
      load_q  <= 1'b0;
      rd_q    <= 1'b0;
      kick_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      xip_q   <= xip_d;
      ack_q   <= ack_d;
      dir_q   <= dir_d;
      wdata_q <= wdata_d;
      load_q  <= load_d;
      rd_q    <= rd_d;
      kick_q  <= kick_d;
    end
  end

  assign sr_wdata_o = wdata_q;
  assign sr_load_o  = load_q;
  assign sr_rd_o    = rd_q;
  assign sr_out_o   = dir_q;
  assign xfer_no    = xip_q;
  assign ack_o      = ack_q;

  AST_STEP_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_i && !(st_q == ST_LISTEN && kick_q)) |=> $stable(st_q)) else $error("step without event"); // R2
  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LISTEN) |-> (xip_q && ack_q && !dir_q)) else $error("idle lines wrong"); // R11
  AST_LOAD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_load_o |-> sr_out_o) else $error("load while shifting in"); // R8
  AST_RD_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_rd_o |-> !sr_out_o) else $error("read while shifting out"); // R10
  AST_SEND_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEND && ev_i && idx_q < tx_len_i) |=> (ack_q != $past(ack_q))) else $error("no toggle"); // R10
  AST_RECV_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RECV) |-> !xip_q) else $error("receive with line idle"); // R3
endmodule

// File: rtl/hs_link_ctrl.sv
module hs_link_ctrl #(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 8,
  localparam int RXC = $clog2(RX_DEPTH + 1),
  localparam int TXA = $clog2(TX_DEPTH),
  localparam int TXC = $clog2(TX_DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sr_done_i,
  input  logic                  req_ni,
  input  logic [7:0]            sr_rdata_i,
  output logic [7:0]            sr_wdata_o,
  output logic                  sr_load_o,
  output logic                  sr_rd_o,
  output logic                  sr_out_o,
  output logic                  xfer_no,
  output logic                  ack_o,
  input  logic                  tx_wr_i,
  input  logic [TXA-1:0]        tx_waddr_i,
  input  logic [7:0]            tx_wdata_i,
  input  logic                  tx_go_i,
  input  logic [TXC-1:0]        tx_len_i,
  input  logic                  poll_set_i,
  input  logic                  poll_on_i,
  output logic                  tx_pend_o,
  output logic                  rx_valid_o,
  output logic [RXC-1:0]        rx_len_o,
  output logic [8*RX_DEPTH-1:0] rx_data_o
);
  logic [TXC-1:0] tx_idx, tx_len;
  logic [7:0]     tx_byte;
  logic           tx_acc, tx_done, rx_wr, rx_flush;

  hs_tx_buf #(.DEPTH(TX_DEPTH)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (tx_wr_i),
    .waddr_i    (tx_waddr_i),
    .wdata_i    (tx_wdata_i),
    .go_i       (tx_go_i),
    .len_i      (tx_len_i),
    .poll_set_i (poll_set_i),
    .poll_on_i  (poll_on_i),
    .done_i     (tx_done),
    .rd_idx_i   (tx_idx),
    .rd_data_o  (tx_byte),
    .len_o      (tx_len),
    .acc_o      (tx_acc)
  );

  hs_rx_buf #(.DEPTH(RX_DEPTH)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (rx_wr),
    .wdata_i (sr_rdata_i),
    .flush_i (rx_flush),
    .valid_o (rx_valid_o),
    .len_o   (rx_len_o),
    .data_o  (rx_data_o)
  );

  hs_link_fsm #(.TX_DEPTH(TX_DEPTH)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (sr_done_i),
    .req_ni     (req_ni),
    .tx_len_i   (tx_len),
    .tx_byte_i  (tx_byte),
    .acc_i      (tx_acc),
    .tx_idx_o   (tx_idx),
    .tx_done_o  (tx_done),
    .rx_wr_o    (rx_wr),
    .rx_flush_o (rx_flush),
    .sr_wdata_o (sr_wdata_o),
    .sr_load_o  (sr_load_o),
    .sr_rd_o    (sr_rd_o),
    .sr_out_o   (sr_out_o),
    .xfer_no    (xfer_no),
    .ack_o      (ack_o)
  );

  assign tx_pend_o = (tx_len != '0);

  AST_PEND_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_pend_o) |-> ($past(sr_done_i) && sr_rd_o)) else $error("pending dropped early"); // R10
endmodule

// File: tb/hs_link_ctrl_tb.sv
module hs_link_ctrl_tb_top;
  localparam int RXD = 16;
  localparam int TXD = 8;
  localparam int LISTEN = 0, RECV = 1, RECV_END = 2, SEND_START = 3, SEND = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sr_done = 1'b0, req_n = 1'b1;
  logic [7:0] sr_rdata = '0;
  logic [7:0] sr_wdata;
  logic sr_load, sr_rd, sr_out, xfer_n, ack;
  logic tx_wr = 1'b0;
  logic [2:0] tx_waddr = '0;
  logic [7:0] tx_wdata = '0;
  logic tx_go = 1'b0;
  logic [3:0] tx_len = '0;
  logic poll_set = 1'b0, poll_on = 1'b0;
  logic tx_pend, rx_valid;
  logic [4:0] rx_len;
  logic [8*RXD-1:0] rx_data;

  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  hs_link_ctrl #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sr_done_i(sr_done), .req_ni(req_n),
    .sr_rdata_i(sr_rdata), .sr_wdata_o(sr_wdata), .sr_load_o(sr_load),
    .sr_rd_o(sr_rd), .sr_out_o(sr_out), .xfer_no(xfer_n), .ack_o(ack),
    .tx_wr_i(tx_wr), .tx_waddr_i(tx_waddr), .tx_wdata_i(tx_wdata),
    .tx_go_i(tx_go), .tx_len_i(tx_len), .poll_set_i(poll_set),
    .poll_on_i(poll_on), .tx_pend_o(tx_pend), .rx_valid_o(rx_valid),
    .rx_len_o(rx_len), .rx_data_o(rx_data)
  );

  // behavioural reference model
  int m_st, m_len, m_idx, m_cnt, m_rxlen, m_wd;
  bit m_xip, m_ack, m_dir, m_load, m_rd, m_rxv, m_kick;
  byte unsigned m_tx[TXD];
  byte unsigned m_rx[RXD];

  task automatic m_start();
    m_st = SEND_START; m_dir = 1; m_load = 1; m_wd = m_tx[0]; m_xip = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = LISTEN; m_len = 0; m_idx = 0; m_cnt = 0; m_rxlen = 0; m_wd = 0;
      m_xip = 1; m_ack = 1; m_dir = 0; m_load = 0; m_rd = 0; m_rxv = 0; m_kick = 0;
      foreach (m_tx[i]) m_tx[i] = 0;
      foreach (m_rx[i]) m_rx[i] = 0;
    end else begin
      int old_st;
      bit acc, fin;
      old_st = m_st; fin = 0; acc = 0;
      m_load = 0; m_rd = 0; m_rxv = 0;
      if (sr_done) begin
        case (m_st)
          LISTEN: if (!req_n) begin m_xip = 0; m_st = RECV; end
          RECV: begin
            if (m_cnt < RXD) begin m_rx[m_cnt] = sr_rdata; m_cnt++; end
            m_rd = 1;
            if (!req_n) m_ack = !m_ack;
            else begin m_ack = 1; m_xip = 1; m_st = RECV_END; end
          end
          RECV_END: begin
            m_rxv = 1; m_rxlen = m_cnt; m_cnt = 0;
            if (!req_n) begin m_xip = 0; m_st = RECV; end
            else begin m_st = LISTEN; if (m_len > 0) m_start(); end
          end
          SEND_START: begin
            if (!req_n) begin m_dir = 0; m_rd = 1; m_xip = 1; m_ack = 1; m_st = LISTEN; end
            else begin m_load = 1; m_wd = m_tx[1]; m_ack = !m_ack; m_idx = 2; m_st = SEND; end
          end
          default: begin
            if (m_idx < m_len) begin m_load = 1; m_wd = m_tx[m_idx]; m_idx++; m_ack = !m_ack; end
            else begin fin = 1; m_dir = 0; m_rd = 1; m_ack = 1; m_xip = 1; m_st = LISTEN; end
          end
        endcase
      end else if (m_st == LISTEN && m_kick && m_len > 0 && req_n) begin
        m_start();
      end
      if (fin) m_len = 0;
      else if (m_len == 0) begin
        if (poll_set) begin
          m_tx[0] = 8'h01; m_tx[1] = 8'h01; m_tx[2] = poll_on ? 8'h01 : 8'h00;
          m_len = 3; acc = 1;
        end else begin
          if (tx_wr) m_tx[tx_waddr] = tx_wdata;
          if (tx_go && tx_len >= 2 && tx_len <= TXD) begin m_len = int'(tx_len); acc = 1; end
        end
      end
      m_kick = acc || (m_kick && old_st == LISTEN && sr_done);
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(xfer_n == m_xip, "R4 xfer_no", int'(xfer_n), int'(m_xip));
      chk(ack == m_ack, "R4 ack_o", int'(ack), int'(m_ack));
      chk(sr_out == m_dir, "R8 sr_out_o", int'(sr_out), int'(m_dir));
      chk(sr_load == m_load, "R10 sr_load_o", int'(sr_load), int'(m_load));
      if (m_load) chk(int'(sr_wdata) == m_wd, "R10 sr_wdata_o", int'(sr_wdata), m_wd);
      chk(sr_rd == m_rd, "R11 sr_rd_o", int'(sr_rd), int'(m_rd));
      chk(tx_pend == (m_len != 0), "R7 tx_pend_o", int'(tx_pend), int'(m_len != 0));
      chk(rx_valid == m_rxv, "R5 rx_valid_o", int'(rx_valid), int'(m_rxv));
      if (m_rxv) begin
        chk(int'(rx_len) == m_rxlen, "R5 rx_len_o", int'(rx_len), m_rxlen);
        for (int i = 0; i < m_rxlen; i++)
          chk(rx_data[8*i +: 8] == m_rx[i], "R6 rx_data_o", int'(rx_data[8*i +: 8]), int'(m_rx[i]));
      end
    end
  end

  task automatic ev(bit rq, logic [7:0] d);
    @(negedge clk); sr_done = 1'b1; req_n = rq; sr_rdata = d;
    @(negedge clk); sr_done = 1'b0;
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_waddr = 3'(a); tx_wdata = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic go(int n);
    @(negedge clk); tx_go = 1'b1; tx_len = 4'(n);
    @(negedge clk); tx_go = 1'b0;
  endtask

  task automatic poll(bit on);
    @(negedge clk); poll_set = 1'b1; poll_on = on;
    @(negedge clk); poll_set = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(xfer_n && ack && !sr_out && !tx_pend && !rx_valid && !sr_load && !sr_rd, "R1 reset", 0, 0);

    // R2 idle event with request high is ignored
    ev(1, 8'hAB);
    chk(xfer_n == 1 && ack == 1 && !sr_rd, "R2 ignored event", int'(xfer_n), 1);

    // R3 / R4 four-byte packet
    ev(0, 8'h00);
    chk(xfer_n == 0, "R3 xfer low", int'(xfer_n), 0);
    ev(0, 8'h11);
    chk(sr_rd == 1 && ack == 0, "R4 toggle", int'(ack), 0);
    ev(0, 8'h22);
    chk(ack == 1, "R4 toggle back", int'(ack), 1);
    ev(0, 8'h33);
    ev(1, 8'h44);
    chk(ack == 1 && xfer_n == 1, "R4 packet end", int'(xfer_n), 1);
    ev(1, 8'h00);
    chk(rx_valid && rx_len == 4 && rx_data[7:0] == 8'h11 && rx_data[31:24] == 8'h44,
        "R5 delivery", int'(rx_len), 4);

    // R5 chained packets
    ev(0, 8'h00);
    ev(1, 8'h55);
    ev(0, 8'h00);
    chk(rx_valid && rx_len == 1 && xfer_n == 0, "R5 chained", int'(xfer_n), 0);
    ev(1, 8'h66);
    ev(1, 8'h00);
    chk(rx_valid && rx_len == 1 && rx_data[7:0] == 8'h66, "R5 second", int'(rx_data[7:0]), 'h66);

    // R6 overflow
    ev(0, 8'h00);
    for (int i = 0; i < 18; i++) ev(i == 17, 8'(8'h80 + i));
    ev(1, 8'h00);
    chk(rx_len == 16 && rx_data[127:120] == 8'h8F, "R6 overflow", int'(rx_len), 16);

    // R7 short length refused
    go(1);
    chk(!tx_pend, "R7 len 1 refused", int'(tx_pend), 0);

    // R8 / R9 / R10 four-byte send
    wr(0, 8'hA0); wr(1, 8'hA1); wr(2, 8'hA2); wr(3, 8'hA3);
    go(4);
    chk(tx_pend, "R7 accepted", int'(tx_pend), 1);
    @(negedge clk);
    chk(sr_load && sr_wdata == 8'hA0 && sr_out && !xfer_n, "R8 start", int'(sr_wdata), 'hA0);
    wr(1, 8'hEE);
    go(2);
    ev(1, 8'h00);
    chk(sr_load && sr_wdata == 8'hA1 && ack == 0, "R9 byte 1", int'(sr_wdata), 'hA1);
    ev(1, 8'h00);
    chk(sr_wdata == 8'hA2 && ack == 1, "R10 byte 2", int'(sr_wdata), 'hA2);
    ev(1, 8'h00);
    chk(sr_wdata == 8'hA3 && ack == 0, "R10 byte 3", int'(sr_wdata), 'hA3);
    ev(1, 8'h00);
    chk(!tx_pend && !sr_out && sr_rd && ack && xfer_n, "R10 end", int'(tx_pend), 0);

    // R11 collision, R12 retry at packet end
    wr(0, 8'hB0); wr(1, 8'hB1);
    go(2);
    @(negedge clk);
    ev(0, 8'h00);
    chk(!sr_out && sr_rd && ack && xfer_n && tx_pend, "R11 collision", int'(tx_pend), 1);
    ev(0, 8'h00);
    ev(1, 8'h77);
    ev(1, 8'h00);
    chk(rx_valid && sr_load && sr_wdata == 8'hB0 && !xfer_n, "R12 retry", int'(sr_wdata), 'hB0);
    ev(1, 8'h00);
    chk(sr_wdata == 8'hB1, "R12 byte 1", int'(sr_wdata), 'hB1);
    ev(1, 8'h00);
    chk(!tx_pend, "R10 done after retry", int'(tx_pend), 0);

    // R8 no start with request low; R13 polling enable
    req_n = 1'b0;
    poll(1);
    repeat (3) @(negedge clk);
    chk(!sr_out && tx_pend, "R8 held while request low", int'(sr_out), 0);
    ev(0, 8'h00);
    ev(1, 8'h99);
    ev(1, 8'h00);
    chk(sr_load && sr_wdata == 8'h01, "R13 byte 0", int'(sr_wdata), 'h01);
    ev(1, 8'h00);
    ev(1, 8'h00);
    chk(sr_wdata == 8'h01, "R13 enable byte", int'(sr_wdata), 'h01);
    ev(1, 8'h00);

    // R13 polling disable, priority over tx_go
    @(negedge clk); poll_set = 1'b1; poll_on = 1'b0; tx_go = 1'b1; tx_len = 4'd5;
    @(negedge clk); poll_set = 1'b0; tx_go = 1'b0;
    @(negedge clk);
    chk(sr_load && sr_wdata == 8'h01, "R13 start", int'(sr_wdata), 'h01);
    ev(1, 8'h00);
    ev(1, 8'h00);
    chk(sr_wdata == 8'h00, "R13 disable byte", int'(sr_wdata), 'h00);
    ev(1, 8'h00);
    chk(!tx_pend, "R13 length 3", int'(tx_pend), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule